// File: doc/BRIEF.md
# Gated 13-Bit Timer/Counter

This block is one timer/counter channel working as a 13-bit up-counter. The count value is split across two readable and writable byte registers: the whole high byte supplies the top eight bits, and the bottom five bits of the low byte supply the rest. The top three bits of the low byte are storage only. Each count step comes either from a divide-by-six tick derived from the block clock (timer use) or from a falling transition on an external count pin (counter use). A select bit in a small control register chooses between the two.

Counting is allowed only while the run bit is set. When the gate-enable bit is also set, counting additionally requires the external gate pin to be high. Software can therefore measure how long that pin stays high by reading the count before and after a pulse. When the count steps from all ones it wraps to zero and raises an overflow flag, which goes to the interrupt logic. The flag is cleared by an acknowledge strobe from that logic, or software can overwrite it through the control register.

Top module: `gtimer13`

## Requirements
- R1: The count is `{hi_q[7:0], lo_q[4:0]}`. Each enabled step adds one, and a carry out of `lo_q[4]` goes into `hi_q[0]`.
- R2: `lo_q[7:5]` keeps the value last written through `wr_lo` and is never changed by counting or by carry.
- R3: A step taken while the count is all ones (hi 0xFF, low five bits 0x1F) makes the count zero on the next cycle. It also sets the overflow flag, which is read at `ctl_q[3]` and driven on `ovf_flag`.
- R4: Steps are taken only when run (`ctl_q[0]`) is 1 and either gate-enable (`ctl_q[1]`) is 0 or `gate_pin` is high. `gate_pin` passes through a two-flop synchronizer first. In every other cycle the count holds.
- R5: With source select (`ctl_q[2]`) at 0, a step is offered on every sixth clock by a prescaler that runs freely from reset. The first offer comes at the sixth rising edge after reset is released. With select at 1, each falling edge on `cnt_pin` gives exactly one step, three rising edges after the pin falls (two-flop synchronizer plus edge flop).
- R6: Writing the run bit never changes the count. After run is cleared and set again, counting resumes from the held value.
- R7: `irq_ack` clears the flag. A control write (`wr_ctl`) loads the flag from `wdata[3]` and loads run, gate-enable and select from `wdata[0]`, `wdata[1]` and `wdata[2]`. If both happen in one cycle, the control write wins.
- R8: If an overflow falls in the same cycle as a control write or `irq_ack`, the flag is 1 afterwards.
- R9: `wr_hi` and `wr_lo` load `wdata` into their byte on the next rising edge. A step offered in that cycle is dropped.
- R10: A synchronous active-low reset clears both bytes, the control bits, the flag, the prescaler and the synchronizers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_pin | input | 1 | Asynchronous external gate input |
| cnt_pin | input | 1 | Asynchronous external count input |
| wr_hi | input | 1 | Write strobe for the high byte |
| wr_lo | input | 1 | Write strobe for the low byte |
| wr_ctl | input | 1 | Write strobe for the control register |
| wdata | input | 8 | Write data shared by all three registers |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| hi_q | output | 8 | High byte readback |
| lo_q | output | 8 | Low byte readback |
| ctl_q | output | 8 | Control readback: bit0 run, bit1 gate-enable, bit2 source select, bit3 flag, bits 7:4 zero |
| ovf_flag | output | 1 | Overflow flag |

## Verification
Two pairs of functions can land in the same cycle. The first is an overflow step together with a flag write or acknowledge. The second is a count step together with a byte load. Both are provoked in counter mode, where the step cycle is fixed at three edges after the pin falls: the bench drives `wr_ctl` with a zero flag bit and `irq_ack`, or `wr_hi`, exactly in that cycle. The result is judged in two ways. A behavioural model running alongside the design predicts the outcome (flag set, loaded byte kept, no increment), and that prediction is compared on every clock. A directed check also reads back the flag and the byte afterwards.

// File: rtl/tmr_pkg.sv
// Shared sizing and control-register bit positions for the 13-bit timer.
// Assumes an 8-bit register interface.
package tmr_pkg;
    localparam int BYTE_W   = 8;
    localparam int LO_BITS  = 5;
    localparam int PRE_DIV  = 6;
    localparam int SYNC_N   = 2;
    localparam int RUN_BIT  = 0;
    localparam int GATE_BIT = 1;
    localparam int SEL_BIT  = 2;
    localparam int FLAG_BIT = 3;
endpackage

// File: rtl/tmr_sync.sv
// Multi-flop synchronizer for an asynchronous level input.
// Assumes N >= 2 and a synchronous active-low reset that clears the chain to 0.
module tmr_sync #(
    parameter int N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [N-1:0] sh;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[N-2:0], din};
    end

    assign dout = sh[N-1];
endmodule

// File: rtl/tmr_fall.sv
// Falling-edge detector on an already synchronized level.
// Gives a one-cycle pulse in the cycle after the level drops.
module tmr_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic lvl_d;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign fall = lvl_d & ~lvl;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R5
endmodule

// File: rtl/tmr_prescale.sv
// Free-running divider: one-cycle tick on every DIV-th clock after reset.
// It does not depend on run or select, so the tick phase is fixed by reset alone.
module tmr_prescale #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pc;

    assign tick = (pc == LAST);

    // Advance the phase counter and wrap it after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= '0;
        else if (tick) pc <= '0;
        else           pc <= pc + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
endmodule

// File: rtl/tmr_count13.sv
// Count register pair plus overflow flag.
// The count is the high byte over the low LO_BITS of the low byte. The low
// byte's upper bits are storage only. Priorities: a byte load beats a step,
// and an overflow beats a flag write, which beats an acknowledge.
module tmr_count13
    import tmr_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int LB = LO_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic          wr_ctl,
    input  logic          irq_ack,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] hi,
    output logic [BW-1:0] lo,
    output logic          flag
);
    localparam int CW = BW + LB;

    logic [CW-1:0] cnt, cnt_inc;
    logic          loaded, at_max, wrap;

    assign cnt     = {hi, lo[LB-1:0]};
    assign cnt_inc = cnt + 1'b1;
    assign loaded  = wr_hi | wr_lo;
    assign at_max  = &cnt;
    assign wrap    = step & ~loaded & at_max;

    // Byte loads take priority; otherwise an offered step increments.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= '0;
            lo <= '0;
        end else if (loaded) begin
            if (wr_hi) hi <= wdata;
            if (wr_lo) lo <= wdata;
        end else if (step) begin
            hi         <= cnt_inc[CW-1:LB];
            lo[LB-1:0] <= cnt_inc[LB-1:0];
        end
    end

    // Overflow flag: set by wrap, loaded by control write, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (wrap)   flag <= 1'b1;
        else if (wr_ctl) flag <= wdata[FLAG_BIT];
        else if (irq_ack) flag <= 1'b0;
    end

    AST_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !loaded && !at_max) |=> (cnt == $past(cnt) + 1'b1)); // R1
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> (lo[BW-1:LB] == $past(lo[BW-1:LB]))); // R2
    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (flag && cnt == '0)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !loaded) |=> $stable(cnt)); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !wr_ctl && !wrap) |=> !flag); // R7
    AST_WRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && (wr_ctl || irq_ack)) |=> flag); // R8
endmodule

// File: rtl/gtimer13.sv
// Gated 13-bit timer/counter channel, top level.
// Holds the control bits, synchronizes both external pins, picks the step
// source and applies the run/gate enable. Pins are asynchronous.
module gtimer13
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate_pin,
    input  logic       cnt_pin,
    input  logic       wr_hi,
    input  logic       wr_lo,
    input  logic       wr_ctl,
    input  logic [7:0] wdata,
    input  logic       irq_ack,
    output logic [7:0] hi_q,
    output logic [7:0] lo_q,
    output logic [7:0] ctl_q,
    output logic       ovf_flag
);
    logic run_r, gate_r, sel_r;
    logic gate_s, cnt_s, cnt_fall, tick, enable, step;

    // Control bits are loaded on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_r  <= 1'b0;
            gate_r <= 1'b0;
            sel_r  <= 1'b0;
        end else if (wr_ctl) begin
            run_r  <= wdata[RUN_BIT];
            gate_r <= wdata[GATE_BIT];
            sel_r  <= wdata[SEL_BIT];
        end
    end

    tmr_sync #(.N(SYNC_N)) u_gsync (
        .clk(clk), .rst_n(rst_n), .din(gate_pin), .dout(gate_s));
    tmr_sync #(.N(SYNC_N)) u_csync (
        .clk(clk), .rst_n(rst_n), .din(cnt_pin), .dout(cnt_s));
    tmr_fall u_fall (
        .clk(clk), .rst_n(rst_n), .lvl(cnt_s), .fall(cnt_fall));
    tmr_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    // Run AND (gate off OR pin high); source chosen by select.
    always_comb begin
        enable = run_r & (~gate_r | gate_s);
        step   = enable & (sel_r ? cnt_fall : tick);
    end

    tmr_count13 u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_ctl(wr_ctl), .irq_ack(irq_ack),
        .wdata(wdata), .hi(hi_q), .lo(lo_q), .flag(ovf_flag));

    // Control readback with the flag in its bit position.
    always_comb begin
        ctl_q           = '0;
        ctl_q[RUN_BIT]  = run_r;
        ctl_q[GATE_BIT] = gate_r;
        ctl_q[SEL_BIT]  = sel_r;
        ctl_q[FLAG_BIT] = ovf_flag;
    end

    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_r && !gate_s && !wr_hi && !wr_lo) |=> $stable({hi_q, lo_q[4:0]})); // R4
endmodule

// File: tb/sim_gtimer13.sv
// Bench for gtimer13: a behavioural model is stepped on every rising edge and
// compared on every falling edge, with directed checks for each requirement.
module sim_gtimer13;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate_pin = 1'b0, cnt_pin = 1'b0;
    logic       wr_hi = 1'b0, wr_lo = 1'b0, wr_ctl = 1'b0, irq_ack = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] hi_q, lo_q, ctl_q;
    logic       ovf_flag;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    gtimer13 u0 (.*);

    always #5 clk = ~clk;

    // Model state
    int m_hi = 0, m_lo = 0, m_pc = 0;
    bit m_run = 0, m_gate = 0, m_sel = 0, m_flag = 0;
    bit p1 = 0, p2 = 0, p3 = 0, g1 = 0, g2 = 0;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        bit tick, fall, en, step, wrap;
        int c;
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_pc = 0; m_run = 0; m_gate = 0; m_sel = 0;
            m_flag = 0; p1 = 0; p2 = 0; p3 = 0; g1 = 0; g2 = 0;
        end else begin
            tick = (m_pc == 5);
            m_pc = tick ? 0 : m_pc + 1;
            fall = p3 && !p2;
            en   = m_run && (!m_gate || g2);
            step = en && (m_sel ? fall : tick);
            p3 = p2; p2 = p1; p1 = cnt_pin;
            g2 = g1; g1 = gate_pin;
            wrap = 0;
            if (wr_hi || wr_lo) begin
                if (wr_hi) m_hi = wdata;
                if (wr_lo) m_lo = wdata;
            end else if (step) begin
                c = m_hi * 32 + (m_lo % 32);
                if (c == 8191) begin c = 0; wrap = 1; end
                else c++;
                m_hi = c / 32;
                m_lo = (m_lo & 8'hE0) | (c % 32);
            end
            if (wrap)         m_flag = 1;
            else if (wr_ctl)  m_flag = wdata[3];
            else if (irq_ack) m_flag = 0;
            if (wr_ctl) begin m_run = wdata[0]; m_gate = wdata[1]; m_sel = wdata[2]; end
        end
    end

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 count", {hi_q, lo_q}, (m_hi << 8) | m_lo);
            check("R7 control", ctl_q, {4'b0, m_flag, m_sel, m_gate, m_run});
            check("R3 flag pin", ovf_flag, m_flag);
        end
    end

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(int which, logic [7:0] d);
        wdata = d;
        wr_hi = (which == 0); wr_lo = (which == 1); wr_ctl = (which == 2);
        @(negedge clk);
        wr_hi = 0; wr_lo = 0; wr_ctl = 0;
    endtask

    function automatic int cval();
        return hi_q * 32 + lo_q[4:0];
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int held;
        clks(3);
        check("R10 reset hi", hi_q, 0);
        check("R10 reset lo", lo_q, 0);
        check("R10 reset ctl", ctl_q, 0);
        rst_n = 1;

        // Timer mode counting, upper low-byte bits kept.
        wreg(0, 8'h12);
        wreg(1, 8'hE3);
        wreg(2, 8'h01);
        clks(61);
        check("R2 upper bits", lo_q[7:5], 3'b111);
        check("R1 advanced", cval() > 12'h243 ? 1 : 0, 1);

        // Run toggle: holds, then resumes.
        wreg(2, 8'h00);
        held = cval();
        clks(20);
        check("R6 held while stopped", cval(), held);
        wreg(2, 8'h01);
        clks(13);
        check("R6 resumed from held", (cval() > held && cval() < held + 4) ? 1 : 0, 1);

        // Wrap from all ones.
        wreg(2, 8'h00);
        wreg(0, 8'hFF);
        wreg(1, 8'h1F);
        wreg(2, 8'h01);
        clks(8);
        check("R3 flag set", ovf_flag, 1);
        check("R3 wrapped low", hi_q, 0);
        irq_ack = 1; clks(1); irq_ack = 0;
        check("R7 ack clears", ovf_flag, 0);

        // Gate on with pin low freezes, pin high counts.
        wreg(2, 8'h03);
        held = cval();
        clks(30);
        check("R4 frozen by gate", cval(), held);
        gate_pin = 1;
        clks(15);
        check("R4 counts with pin high", cval() > held ? 1 : 0, 1);
        gate_pin = 0;

        // External count mode: five pulses give five steps.
        wreg(2, 8'h04);
        clks(4);
        wreg(2, 8'h05);
        held = cval();
        for (int i = 0; i < 5; i++) begin
            cnt_pin = 1; clks(4);
            cnt_pin = 0; clks(4);
        end
        check("R5 five edges", cval(), held + 5);

        // Collision: overflow with control write (flag 0) and acknowledge.
        wreg(0, 8'hFF);
        wreg(1, 8'h1F);
        cnt_pin = 1; clks(4);
        cnt_pin = 0; clks(2);
        wdata = 8'h05; wr_ctl = 1; irq_ack = 1;
        clks(1);
        wr_ctl = 0; irq_ack = 0;
        check("R8 overflow beats clear", ovf_flag, 1);
        check("R8 count wrapped", cval(), 0);
        wreg(2, 8'h0D);
        check("R7 write sets flag", ovf_flag, 1);
        wreg(2, 8'h05);
        check("R7 write clears flag", ovf_flag, 0);

        // Collision: byte load in the step cycle drops the step.
        cnt_pin = 1; clks(4);
        cnt_pin = 0; clks(2);
        wdata = 8'h40; wr_hi = 1;
        clks(1);
        wr_hi = 0;
        check("R9 load wins", cval(), 8'h40 * 32);
        clks(4);
        check("R9 no late step", cval(), 8'h40 * 32);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule